// File: doc/BRIEF.md
# Toggle-Point Timing Pulse Generator

This block builds eight programmable timing waveforms for one image-sensor line. A free-running pixel counter restarts on every line-start strobe. A shared pool of thirty-two toggle points is compared against that counter. Each toggle point names a pixel position and the pulse it drives, and every match flips the level of that pulse. Each pulse has its own idle level, set by a polarity bit. A crossbar then places any pulse on any of ten clock pins.

Software writes toggle points, polarity bits and pin selectors through a simple write port into a staging copy. The staged copy becomes active only on a line-start strobe, so a waveform never changes shape part-way through a line. The counter stops at its top value, and no toggle happens before the first line start.

Address map of the write port: addresses 0 to 31 hold toggle points. In each, data bits [11:0] are the pixel position, bits [14:12] are the pulse index, and bit 15 is the enable. Addresses 32 to 39 hold the polarity of pulses 0 to 7 in data bit 0. Addresses 40 to 49 hold the selectors for clock pins 2 to 11, which appear as `pin_out[0]` to `pin_out[9]`, in data bits [3:0].

Top module: `tpg_top`

## Requirements
- R1: While `rst_n` is low, and until the first line start after it, `pulse_out` and `pin_out` are all zero.
- R2: The clock edge that samples `line_start` high clears the pixel count and sets each `pulse_out` bit to its idle level. This also holds when the strobe arrives part-way through a line.
- R3: An enabled toggle point with position P flips its pulse on the clock edge where the count equals P. The count is 0 on the first edge after the line-start edge, so the change appears on `pulse_out` after the (P+1)-th edge following the line-start edge.
- R4: The toggle-point pool is shared. Any entry may target any pulse, several entries on one pulse give several edges, and entries with bit 15 clear have no effect.
- R5: Two enabled toggle points that name the same pulse and the same position cause one flip, not two.
- R6: A polarity bit of 1 makes that pulse idle high and inverts its whole waveform. Each pulse's polarity is independent.
- R7: A pin selector value from 0 to 7 drives that pin with the named pulse.
- R8: A pin selector value from 8 to 15, the reset value, drives the pin low.
- R9: Writes go to a staging copy. Toggle points, polarity and selectors change the outputs only from the next line-start edge on.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Pixel clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| line_start | input | 1 | Line-start strobe, one cycle |
| wr_en | input | 1 | Register write enable |
| wr_addr | input | 6 | Register write address |
| wr_data | input | 16 | Register write data |
| pulse_out | output | 8 | Generated timing pulses |
| pin_out | output | 10 | Clock pins 2 to 11 after routing |

## Verification
The hardest case to provoke from the ports is two toggle points landing on one pulse in the same cycle, because it only shows up when both entries are enabled, both target the same pulse and both match the count together. The stimulus loads two pool entries with identical position and pulse index, alongside other pulses with edges on neighbouring pixels. It then walks the line cycle by cycle so that a double flip, which would cancel itself, appears as a missing edge. Staging is tested by rewriting polarity, a toggle point and a selector mid-line, then confirming the outputs stay put until the next strobe. A second strobe is sent part-way through a line to confirm the restart.

// File: rtl/tpg_pkg.sv
package tpg_pkg;
    localparam int PIX_W      = 12;
    localparam int PULSES     = 8;
    localparam int PSEL_W     = $clog2(PULSES);
    localparam int RSEL_W     = 4;
    localparam int ADDR_W     = 6;
    localparam int DATA_W     = 16;
    localparam int TP_BASE    = 0;
    localparam int POL_BASE   = 32;
    localparam int ROUTE_BASE = 40;

    // one pool entry; packs exactly onto the 16-bit write data
    typedef struct packed {
        logic              en;
        logic [PSEL_W-1:0] pulse;
        logic [PIX_W-1:0]  pos;
    } tp_t;
endpackage

// File: rtl/tpg_regs.sv
module tpg_regs
    import tpg_pkg::*;
#(
    parameter int NUM_TP   = 32,
    parameter int NUM_PINS = 10
) (
    input  logic                              clk,
    input  logic                              rst_n,
    input  logic                              line_start,
    input  logic                              wr_en,
    input  logic [ADDR_W-1:0]                 wr_addr,
    input  logic [DATA_W-1:0]                 wr_data,
    output tp_t  [NUM_TP-1:0]                 tp_act,
    output logic [PULSES-1:0]                 pol_act,
    output logic [PULSES-1:0]                 pol_stage,
    output logic [NUM_PINS-1:0][RSEL_W-1:0]   rt_act
);
    typedef struct packed {
        tp_t  [NUM_TP-1:0]               tp_sh;
        tp_t  [NUM_TP-1:0]               tp_ac;
        logic [PULSES-1:0]               pol_sh;
        logic [PULSES-1:0]               pol_ac;
        logic [NUM_PINS-1:0][RSEL_W-1:0] rt_sh;
        logic [NUM_PINS-1:0][RSEL_W-1:0] rt_ac;
    } regs_t;

    regs_t r_d, r_q;

    always_comb begin
        r_d = r_q;
        for (int i = 0; i < NUM_TP; i++)
            if (wr_en && wr_addr == ADDR_W'(TP_BASE + i))
                r_d.tp_sh[i] = tp_t'(wr_data);
        for (int i = 0; i < PULSES; i++)
            if (wr_en && wr_addr == ADDR_W'(POL_BASE + i))
                r_d.pol_sh[i] = wr_data[0];
        for (int i = 0; i < NUM_PINS; i++)
            if (wr_en && wr_addr == ADDR_W'(ROUTE_BASE + i))
                r_d.rt_sh[i] = wr_data[RSEL_W-1:0];
        if (line_start) begin
            r_d.tp_ac  = r_q.tp_sh;
            r_d.pol_ac = r_q.pol_sh;
            r_d.rt_ac  = r_q.rt_sh;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            r_q       <= '0;
            r_q.rt_sh <= '1;
            r_q.rt_ac <= '1;
        end else begin
            r_q <= r_d;
        end
    end

    assign tp_act    = r_q.tp_ac;
    assign pol_act   = r_q.pol_ac;
    assign pol_stage = r_q.pol_sh;
    assign rt_act    = r_q.rt_ac;
endmodule

// File: rtl/tpg_match.sv
module tpg_match
    import tpg_pkg::*;
#(
    parameter int NUM_TP = 32
) (
    input  tp_t  [NUM_TP-1:0] tp,
    input  logic [PIX_W-1:0]  cnt,
    output logic [PULSES-1:0] hit
);
    // per pulse: OR of all matching entries, so coincident entries flip once
    for (genvar p = 0; p < PULSES; p++) begin : g_pulse
        logic any;
        always_comb begin
            any = 1'b0;
            for (int t = 0; t < NUM_TP; t++)
                if (tp[t].en && tp[t].pulse == PSEL_W'(p) && tp[t].pos == cnt)
                    any = 1'b1;
        end
        assign hit[p] = any;
    end
endmodule

// File: rtl/tpg_route.sv
module tpg_route
    import tpg_pkg::*;
#(
    parameter int NUM_PINS = 10
) (
    input  logic [PULSES-1:0]               pulse,
    input  logic [NUM_PINS-1:0][RSEL_W-1:0] rt,
    output logic [NUM_PINS-1:0]             pins
);
    for (genvar k = 0; k < NUM_PINS; k++) begin : g_pin
        assign pins[k] = (rt[k] < RSEL_W'(PULSES)) ? pulse[rt[k][PSEL_W-1:0]] : 1'b0;
    end
endmodule

// File: rtl/tpg_top.sv
module tpg_top
    import tpg_pkg::*;
#(
    parameter int NUM_TP   = 32,
    parameter int NUM_PINS = 10
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                line_start,
    input  logic                wr_en,
    input  logic [ADDR_W-1:0]   wr_addr,
    input  logic [DATA_W-1:0]   wr_data,
    output logic [PULSES-1:0]   pulse_out,
    output logic [NUM_PINS-1:0] pin_out
);
    localparam logic [PIX_W-1:0] CNT_MAX = '1;

    typedef struct packed {
        logic [PIX_W-1:0]  cnt;
        logic              run;
        logic [PULSES-1:0] lvl;
    } line_t;

    line_t s_d, s_q;

    tp_t  [NUM_TP-1:0]               tp_act;
    logic [PULSES-1:0]               pol_act;
    logic [PULSES-1:0]               pol_stage;
    logic [NUM_PINS-1:0][RSEL_W-1:0] rt_act;
    logic [PULSES-1:0]               hit;
    logic [PIX_W-1:0]                cnt_q;
    logic                            run_q;

    tpg_regs #(.NUM_TP(NUM_TP), .NUM_PINS(NUM_PINS)) u_regs (
        .clk(clk), .rst_n(rst_n), .line_start(line_start),
        .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
        .tp_act(tp_act), .pol_act(pol_act), .pol_stage(pol_stage), .rt_act(rt_act)
    );

    tpg_match #(.NUM_TP(NUM_TP)) u_match (
        .tp(tp_act), .cnt(s_q.cnt), .hit(hit)
    );

    always_comb begin
        s_d = s_q;
        if (line_start) begin
            s_d.cnt = '0;
            s_d.run = 1'b1;
            s_d.lvl = pol_stage;
        end else if (s_q.run) begin
            s_d.lvl = s_q.lvl ^ hit;
            if (s_q.cnt == CNT_MAX) s_d.run = 1'b0;
            else                    s_d.cnt = s_q.cnt + 1'b1;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) s_q <= '0;
        else        s_q <= s_d;
    end

    assign pulse_out = s_q.lvl;
    assign cnt_q     = s_q.cnt;
    assign run_q     = s_q.run;

    tpg_route #(.NUM_PINS(NUM_PINS)) u_route (
        .pulse(s_q.lvl), .rt(rt_act), .pins(pin_out)
    );
endmodule

// File: rtl/tpg_chk.sv
module tpg_chk
    import tpg_pkg::*;
#(
    parameter int NUM_TP   = 32,
    parameter int NUM_PINS = 10
) (
    input logic                              clk,
    input logic                              rst_n,
    input logic                              line_start,
    input logic [PULSES-1:0]                 pulse_out,
    input logic [NUM_PINS-1:0]               pin_out,
    input tp_t  [NUM_TP-1:0]                 tp_act,
    input logic [PULSES-1:0]                 pol_act,
    input logic [NUM_PINS-1:0][RSEL_W-1:0]   rt_act,
    input logic [PIX_W-1:0]                  cnt_q,
    input logic                              run_q
);
    AST_IDLE_ON_START: assert property (@(posedge clk) disable iff (!rst_n)
        line_start |=> pulse_out == pol_act); // R2

    AST_CFG_HELD: assert property (@(posedge clk) disable iff (!rst_n)
        !line_start |=> $stable(tp_act) && $stable(pol_act) && $stable(rt_act)); // R9

    AST_QUIET_WHEN_STOPPED: assert property (@(posedge clk) disable iff (!rst_n)
        (!line_start && !run_q) |=> $stable(pulse_out)); // R3

    AST_COUNT_STEP: assert property (@(posedge clk) disable iff (!rst_n)
        (run_q && !line_start) |=> (!run_q || cnt_q == $past(cnt_q) + 1'b1)); // R3

    AST_PIN_NEEDS_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
        (|pin_out) |-> (|pulse_out)); // R7
endmodule

bind tpg_top tpg_chk #(.NUM_TP(NUM_TP), .NUM_PINS(NUM_PINS)) u_chk (
    .clk(clk), .rst_n(rst_n), .line_start(line_start),
    .pulse_out(pulse_out), .pin_out(pin_out),
    .tp_act(tp_act), .pol_act(pol_act), .rt_act(rt_act),
    .cnt_q(cnt_q), .run_q(run_q)
);

// File: tb/tb_tpg_top.sv
module tb_tpg_top;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        line_start = 1'b0;
    logic        wr_en = 1'b0;
    logic [5:0]  wr_addr = '0;
    logic [15:0] wr_data = '0;
    logic [7:0]  pulse_out;
    logic [9:0]  pin_out;

    int checks = 0;
    int fails  = 0;
    int cycles = 0;

    tpg_top dut (
        .clk(clk), .rst_n(rst_n), .line_start(line_start),
        .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
        .pulse_out(pulse_out), .pin_out(pin_out)
    );

    always #10 clk = ~clk; // 50 MHz

    // expected pulse_out after edge n of the first line
    localparam logic [7:0] LINE1 [11] = '{8'h0C, 8'h08, 8'h08, 8'h09, 8'h0B,
                                         8'h8B, 8'h8A, 8'h0A, 8'h0A, 8'h0A, 8'h0A};

    task automatic chk(input string req, input logic [15:0] got, input logic [15:0] exp);
        checks++;
        if (got !== exp) begin
            fails++;
            $display("FAIL %s: got %h expected %h", req, got, exp);
        end
    endtask

    task automatic wr(input int addr, input logic [15:0] data);
        @(negedge clk);
        wr_en = 1'b1; wr_addr = 6'(addr); wr_data = data;
        @(negedge clk);
        wr_en = 1'b0;
    endtask

    function automatic logic [15:0] tp(input int pulse, input int pos);
        return {1'b1, 3'(pulse), 12'(pos)};
    endfunction

    // routing 1: pin0<-p0, pin1<-p3, pin2 sel 9 (low), pin9<-p7
    function automatic logic [9:0] pins1(input logic [7:0] p);
        return {p[7], 7'b0, p[3], p[0]};
    endfunction
    // routing 2: pin2 now <- p4
    function automatic logic [9:0] pins2(input logic [7:0] p);
        return {p[7], 6'b0, p[4], p[3], p[0]};
    endfunction

    task automatic strobe();
        @(negedge clk); line_start = 1'b1;
        @(negedge clk); line_start = 1'b0; // now just after edge n=0
    endtask

    task automatic report();
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    endtask

    always @(posedge clk) begin
        cycles++;
        if (cycles > 20000) begin
            checks++; fails++;
            $display("FAIL watchdog: got %0d cycles expected fewer", cycles);
            report();
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        chk("R1 pulses in reset", 16'(pulse_out), 16'h0);
        chk("R1 pins in reset", 16'(pin_out), 16'h0);
        rst_n = 1'b1;

        // configuration: shared pool, coincident pair, two polarities
        wr(0, tp(0, 2));  wr(1, tp(0, 5));
        wr(2, tp(1, 3));  wr(3, tp(1, 3));   // R5 coincident
        wr(4, tp(2, 0));  wr(31, tp(7, 4)); wr(5, tp(7, 6));
        wr(6, {1'b0, 3'd6, 12'd1});          // R4 disabled entry
        wr(32 + 2, 16'h1); wr(32 + 3, 16'h1);
        wr(40 + 0, 16'd0); wr(40 + 1, 16'd3); wr(40 + 2, 16'd9); wr(40 + 9, 16'd7);
        repeat (4) @(negedge clk);
        chk("R9 staged pulses before first line", 16'(pulse_out), 16'h0);
        chk("R9 staged pins before first line", 16'(pin_out), 16'h0);

        // table walk over line 1
        strobe();
        for (int n = 0; n < 11; n++) begin
            if (n > 0) @(negedge clk);
            case (n)
                0: chk("R2 idle levels at line start", 16'(pulse_out), 16'(LINE1[n]));
                1: chk("R6 inverted pulse edge", 16'(pulse_out), 16'(LINE1[n]));
                4: chk("R5 coincident toggle points", 16'(pulse_out), 16'(LINE1[n]));
                5: chk("R4 pool entry 31 on pulse 7", 16'(pulse_out), 16'(LINE1[n]));
                default: chk("R3 toggle timing", 16'(pulse_out), 16'(LINE1[n]));
            endcase
            chk("R7 R8 routed pins", 16'(pin_out), 16'(pins1(LINE1[n])));
        end

        // mid-line rewrites must wait for the next strobe
        wr(32 + 4, 16'h1); wr(7, tp(4, 1)); wr(40 + 2, 16'd4);
        repeat (3) @(negedge clk);
        chk("R9 mid-line writes held (pulses)", 16'(pulse_out), 16'h0A);
        chk("R9 mid-line writes held (pins)", 16'(pin_out), 16'(pins1(8'h0A)));

        // line 2
        strobe();
        chk("R6 new idle high pulse 4", 16'(pulse_out), 16'h1C);
        chk("R7 new selector pin2", 16'(pin_out), 16'(pins2(8'h1C)));
        @(negedge clk); chk("R3 line2 n1", 16'(pulse_out), 16'h18);
        @(negedge clk); chk("R4 new entry on pulse 4", 16'(pulse_out), 16'h08);
        chk("R7 pin2 follows pulse 4", 16'(pin_out), 16'(pins2(8'h08)));
        @(negedge clk); chk("R3 line2 n3", 16'(pulse_out), 16'h09);

        // restart part-way through the line
        strobe();
        chk("R2 mid-line restart", 16'(pulse_out), 16'h1C);
        @(negedge clk); chk("R2 count restarted", 16'(pulse_out), 16'h18);
        @(negedge clk); chk("R2 count restarted n2", 16'(pulse_out), 16'h08);
        chk("R8 unrouted pins low", 16'(pin_out & 10'h1F8), 16'h0);

        report();
    end
endmodule